// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

The block gathers a parameterised number of level-sensitive interrupt sources (64 by default) into a single request line to the processor. Each source has an enable bit. A source counts as pending while its level is high and its enable is set. The combined request is high while at least one source is pending, and it follows source changes combinationally.

Software reaches the block through a 32-bit register port that is word-addressed inside a 4 KB window. The register index is the byte address shifted right by two. Software can read an identifier, the number of pending sources, the lowest-numbered pending source and the source count. It sets or clears one enable by writing that source's number, and clears all enables with a single write. Reads return data combinationally in the same cycle. Writes take effect at the next rising clock edge.

Top module: `irq_agg`

## Requirements
- R1: After reset every enable bit is clear, so irq_o is low and reading index 1 returns 0, whatever the source levels.
- R2: Reading index 0 (byte address 0x000) returns 0xC51D0000.
- R3: A write of value n to index 5 (byte 0x014) sets the enable of source n from the next clock edge. A write of n to index 4 (byte 0x010) clears it.
- R4: A write to index 4 or 5 whose value is greater than or equal to N_SRC changes no enable bit.
- R5: Any write to index 3 (byte 0x00C) clears all enable bits, whatever the write data.
- R6: irq_o is high exactly when some source is both high and enabled. It changes in the same cycle as src_i, with no register in the path.
- R7: Reading index 1 (byte 0x004) returns the count of pending sources.
- R8: Reading index 2 (byte 0x008) returns the lowest pending source number, or 0xFFFFFFFF when no source is pending.
- R9: Reading index 6 (byte 0x018) returns N_SRC. Reading any other index in the window returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Source levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as rd_en_i, 0 otherwise |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are the ones that depend on a combination of many enables: a full pending vector, where the count reaches N_SRC, and a single pending source at the highest index, which must still win the lowest-index search. To get there, the bench enables the sources one at a time through index 5. Between writes it drives walking-one and all-ones source patterns and checks the count and the lowest index after every step. It also writes out-of-range indices next to fully enabled and fully disabled states, and checks that nothing changed.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam logic [31:0] ID_VALUE = 32'hC51D_0000;
  localparam logic [31:0] NONE_VALUE = 32'hFFFF_FFFF;
  typedef enum logic [2:0] {
    REG_ID      = 3'd0,
    REG_COUNT   = 3'd1,
    REG_LOWEST  = 3'd2,
    REG_CLR_ALL = 3'd3,
    REG_CLR_ONE = 3'd4,
    REG_SET_ONE = 3'd5,
    REG_NSRC    = 3'd6
  } reg_idx_e;
endpackage

// File: rtl/irq_agg_popcnt.sv
module irq_agg_popcnt #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/irq_agg_lowest.sv
module irq_agg_lowest #(
  parameter int W  = 64,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_agg_enables.sv
module irq_agg_enables #(
  parameter int N_SRC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             set_one_i,
  input  logic             clr_one_i,
  input  logic [31:0]      sel_i,
  output logic [N_SRC-1:0] en_o
);
  logic in_range;
  assign in_range = sel_i < 32'(N_SRC);

  for (genvar g = 0; g < N_SRC; g++) begin : g_en
    logic hit;
    assign hit = in_range && (sel_i == 32'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 en_o[g] <= 1'b0;
      else if (clr_all_i)          en_o[g] <= 1'b0;
      else if (set_one_i && hit)   en_o[g] <= 1'b1;
      else if (clr_one_i && hit)   en_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  localparam int CW = $clog2(N_SRC + 1);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [9:0]       word;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0] pend;
  logic [CW-1:0]    cnt;
  logic             any;
  logic [IW-1:0]    low;

  assign word = addr_i[11:2];

  irq_agg_enables #(.N_SRC(N_SRC)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (wr_en_i && word == 10'(REG_CLR_ALL)),
    .set_one_i (wr_en_i && word == 10'(REG_SET_ONE)),
    .clr_one_i (wr_en_i && word == 10'(REG_CLR_ONE)),
    .sel_i     (wdata_i),
    .en_o      (en)
  );

  assign pend = src_i & en;

  irq_agg_popcnt #(.W(N_SRC), .CW(CW)) u_cnt (.vec_i(pend), .cnt_o(cnt));
  irq_agg_lowest #(.W(N_SRC), .IW(IW)) u_low (.vec_i(pend), .any_o(any), .idx_o(low));

  assign irq_o = any;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (word)
        10'(REG_ID):     rdata_o = ID_VALUE;
        10'(REG_COUNT):  rdata_o = 32'(cnt);
        10'(REG_LOWEST): rdata_o = any ? 32'(low) : NONE_VALUE;
        10'(REG_NSRC):   rdata_o = 32'(N_SRC);
        default:         rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_SRC = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [11:0]      addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             irq_o
);
  // R2
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] == 10'd0) |-> rdata_o == 32'hC51D0000) else $error("id_value_chk");
  // R9
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] == 10'd6) |-> rdata_o == 32'(N_SRC)) else $error("nsrc_value_chk");
  // R9
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] > 10'd6) |-> rdata_o == 32'd0) else $error("undef_zero_chk");
  // R6
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> !irq_o) else $error("idle_low_chk");
  // R8
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] == 10'd2) |-> ((rdata_o == 32'hFFFFFFFF) == !irq_o)) else $error("lowest_none_chk");
  // R7
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] == 10'd1) |-> ((rdata_o != 0) == irq_o && rdata_o <= 32'(N_SRC))) else $error("count_bound_chk");
  // R5
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[11:2] == 10'd3) |=> !irq_o) else $error("clear_all_chk");
  // R8
  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[11:2] == 10'd2 && irq_o) |-> (rdata_o < 32'(N_SRC) && src_i[rdata_o[$clog2(N_SRC)-1:0]])) else $error("lowest_src_chk");
endmodule

bind irq_agg irq_agg_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic wr = 0, rd = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  logic [N-1:0] en_m = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_agg #(.N_SRC(N)) dut_i (.clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr),
    .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] v);
    @(negedge clk); wr = 1; addr = 12'(idx * 4); wdata = v;
    @(negedge clk); wr = 0;
  endtask

  function automatic logic [31:0] rd_now(input int idx);
    return 32'(idx);
  endfunction

  task automatic rd_reg(input int idx, output logic [31:0] v);
    rd = 1; addr = 12'(idx * 4); #1; v = rdata; rd = 0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v, ec, el;
    logic [N-1:0] p;
    p = src & en_m;
    ec = 0; el = 32'hFFFFFFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) begin ec++; el = 32'(i); end
    #1;
    chk({req, " irq"}, {31'd0, irq}, {31'd0, |p});
    rd_reg(1, v); chk({req, " R7 count"}, v, ec);
    rd_reg(2, v); chk({req, " R8 lowest"}, v, el);
  endtask

  initial begin
    logic [31:0] v;
    src = '1;
    #22 rst_n = 1;
    @(negedge clk);
    // R1
    check_all("R1");
    // R2 R9
    rd_reg(0, v); chk("R2", v, 32'hC51D0000);
    rd_reg(6, v); chk("R9 nsrc", v, N);
    rd_reg(7, v); chk("R9 undef", v, 0);
    rd_reg(3, v); chk("R9 wo", v, 0);
    rd_reg(1023, v); chk("R9 top", v, 0);
    // R3 walking enables with walking source
    for (int k = 0; k < N; k++) begin
      wr_reg(5, k); en_m[k] = 1;
      for (int s = 0; s < N; s++) begin
        src = N'(1) << s; check_all("R3 walk");
      end
      src = '1; check_all("R6 allones");
    end
    // R4 out of range at full enable
    src = '1;
    wr_reg(4, N); wr_reg(4, 32'hFFFFFFFF); wr_reg(4, N + 16);
    check_all("R4 clr oob");
    // R6 single top source
    src = N'(1) << (N - 1); check_all("R6 top");
    // R3 clear individually from bottom
    src = '1;
    for (int k = 0; k < N; k++) begin
      wr_reg(4, k); en_m[k] = 0; check_all("R3 clr");
    end
    wr_reg(5, N); wr_reg(5, 32'h8000_0000);
    check_all("R4 set oob");
    // R5
    for (int k = 0; k < N; k += 3) begin wr_reg(5, k); en_m[k] = 1; end
    src = 16'hA5C3; check_all("R6 pattern");
    wr_reg(3, 32'hDEAD_BEEF); en_m = '0;
    check_all("R5");
    // R6 combinational follow
    wr_reg(5, 9); en_m[9] = 1;
    src = '0; #1 chk("R6 low", {31'd0, irq}, 0);
    src[9] = 1; #1 chk("R6 high", {31'd0, irq}, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule